// File: doc/BRIEF.md
# Strobe-Timed Parallel Word Transfer

This block carries parallel words between a sending side and a receiving side that do not share timing, using a single strobe line and no reply line. Both sides live in one module. Each side synchronizes the strobe it receives before using it. A mode input picks which side starts a transfer.

When `mode` is low, the sender starts the transfer. It puts the word on the bus with the output enable raised and waits a counted setup window. It then pulses the strobe and keeps the word on the bus for a counted hold window after the strobe falls. When `mode` is high, the receiver starts the transfer. It raises the strobe to ask for a word, and the sender answers from a word it was given earlier. The receiver takes whatever is on the bus at the moment it lowers the strobe. Neither side learns whether the other side did its part.

The surrounding logic offers words through a valid/ready pair and asks for words through a request input with a busy flag. Any request that arrives while a strobe cycle is still running is ignored.

Top module: `strobe_xfer`

## Requirements
- R1: While reset is held, `src_bus_oe`, `src_stb_out`, `dst_stb_out`, `dst_busy` and `dst_valid` are low and `src_ready` is high.
- R2: With `mode`=0, a word taken when `src_valid` and `src_ready` are both high appears on `src_bus_data`, with `src_bus_oe` high, from the next cycle. `src_stb_out` stays low for SETUP_CYC cycles and then goes high for PULSE_CYC cycles. `src_bus_data` equals the accepted word whenever `src_bus_oe` is high.
- R3: With `mode`=0, `src_bus_oe` stays high for HOLD_CYC cycles after `src_stb_out` falls and then goes low. It is low at every other time.
- R4: With `mode`=0, the receiver passes `dst_stb_in` through two flops and latches `dst_bus_data` on the synchronized rising edge. As a result, `dst_valid` is high for one cycle starting 3 cycles after `dst_stb_in` first reads high, and `dst_data` holds the latched word.
- R5: `src_ready` is low from the cycle after acceptance until the sender's transfer is over. `src_valid` has no effect while `src_ready` is low.
- R6: With `mode`=1, a `dst_req` seen while `dst_busy` is low raises `dst_stb_out` for SETUP_CYC+3 cycles. `dst_bus_data` is latched at the edge where the strobe drops, and `dst_valid` pulses for one cycle. `dst_busy` stays high for HOLD_CYC+3 further cycles, and `dst_req` is ignored while `dst_busy` is high.
- R7: With `mode`=1, a word accepted by the sender is held off the bus (`src_bus_oe` low) until the synchronized rise of `src_stb_in`. The word is driven from 3 cycles after the strobe rises. It stays on the bus until HOLD_CYC cycles after the synchronized fall, which is 3 cycles after the strobe falls.
- R8: With `mode`=1, a request that arrives while the sender holds no word still completes, and it latches the undriven bus. If a word is accepted on the same edge that the rise is detected, that rise is missed, and the word is kept for the next request.
- R9: With `mode`=0, `dst_req` is ignored (`dst_stb_out` and `dst_busy` stay low). With `mode`=1, `src_stb_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | 0: sender drives strobe; 1: receiver drives strobe |
| src_valid | input | 1 | Local word offered to sender |
| src_data | input | DW | Local word |
| src_ready | output | 1 | Sender can take a word |
| src_bus_data | output | DW | Word driven toward the bus |
| src_bus_oe | output | 1 | Bus driver enable |
| src_stb_out | output | 1 | Strobe driven by sender |
| src_stb_in | input | 1 | Strobe seen by sender |
| dst_req | input | 1 | Local request for a word |
| dst_busy | output | 1 | Receiver request in progress |
| dst_stb_out | output | 1 | Strobe driven by receiver |
| dst_stb_in | input | 1 | Strobe seen by receiver |
| dst_bus_data | input | DW | Word read from the bus |
| dst_valid | output | 1 | One-cycle pulse: new word latched |
| dst_data | output | DW | Last latched word |

## Verification
The collision of interest is in receiver-started mode. It happens when the sender accepts a local word on the very edge where its synchronizer first detects the strobe rise. The bench raises `dst_req` and then places `src_valid` exactly three edges later, so acceptance and rise detection fall on the same edge. It expects the request to return the undriven bus value and the stored word to come out on the following request. A second overlap, `src_valid` held high through the last hold cycle, is also driven, and it is judged by a per-cycle reference of `src_ready` and the bus.

// File: rtl/strobe_xfer.sv
module strobe_xfer #(
  parameter int DW        = 8,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,
  input  logic          src_valid,
  input  logic [DW-1:0] src_data,
  output logic          src_ready,
  output logic [DW-1:0] src_bus_data,
  output logic          src_bus_oe,
  output logic          src_stb_out,
  input  logic          src_stb_in,
  input  logic          dst_req,
  output logic          dst_busy,
  output logic          dst_stb_out,
  input  logic          dst_stb_in,
  input  logic [DW-1:0] dst_bus_data,
  output logic          dst_valid,
  output logic [DW-1:0] dst_data
);
  localparam int REQ_CYC = SETUP_CYC + 3;
  localparam int GAP_CYC = HOLD_CYC + 3;
  localparam int CW = $clog2(SETUP_CYC + PULSE_CYC + HOLD_CYC + 8);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STB, S_HOLD, S_ARMED, S_DRIVE} src_st_t;
  typedef enum logic [1:0] {D_IDLE, D_REQ, D_GAP} dst_st_t;

  src_st_t        s_st;
  dst_st_t        d_st;
  logic [CW-1:0]  s_cnt, d_cnt;
  logic [DW-1:0]  s_word;
  logic [2:0]     s_sync, d_sync;

  wire s_rise = s_sync[1] & ~s_sync[2];
  wire s_fall = ~s_sync[1] & s_sync[2];
  wire d_rise = d_sync[1] & ~d_sync[2];

  assign src_ready    = (s_st == S_IDLE);
  assign src_bus_oe   = s_st inside {S_SETUP, S_STB, S_HOLD, S_DRIVE};
  assign src_stb_out  = (s_st == S_STB);
  assign src_bus_data = s_word;
  assign dst_stb_out  = (d_st == D_REQ);
  assign dst_busy     = (d_st != D_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sync <= '0;
      d_sync <= '0;
    end else begin
      s_sync <= {s_sync[1:0], src_stb_in};
      d_sync <= {d_sync[1:0], dst_stb_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_st   <= S_IDLE;
      s_cnt  <= '0;
      s_word <= '0;
    end else begin
      case (s_st)
        S_IDLE: if (src_valid) begin
          s_word <= src_data;
          if (mode) s_st <= S_ARMED;
          else begin
            s_st  <= S_SETUP;
            s_cnt <= CW'(SETUP_CYC - 1);
          end
        end
        S_SETUP: if (s_cnt == '0) begin
          s_st  <= S_STB;
          s_cnt <= CW'(PULSE_CYC - 1);
        end else s_cnt <= s_cnt - 1'b1;
        S_STB: if (s_cnt == '0) begin
          s_st  <= S_HOLD;
          s_cnt <= CW'(HOLD_CYC - 1);
        end else s_cnt <= s_cnt - 1'b1;
        S_HOLD: if (s_cnt == '0) s_st <= S_IDLE;
                else s_cnt <= s_cnt - 1'b1;
        S_ARMED: if (s_rise) s_st <= S_DRIVE;
        S_DRIVE: if (s_fall) begin
          s_st  <= S_HOLD;
          s_cnt <= CW'(HOLD_CYC - 1);
        end
        default: s_st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_st      <= D_IDLE;
      d_cnt     <= '0;
      dst_valid <= 1'b0;
      dst_data  <= '0;
    end else begin
      dst_valid <= 1'b0;
      case (d_st)
        D_IDLE: if (mode && dst_req) begin
          d_st  <= D_REQ;
          d_cnt <= CW'(REQ_CYC - 1);
        end else if (!mode && d_rise) begin
          dst_data  <= dst_bus_data;
          dst_valid <= 1'b1;
        end
        D_REQ: if (d_cnt == '0) begin
          dst_data  <= dst_bus_data;
          dst_valid <= 1'b1;
          d_st      <= D_GAP;
          d_cnt     <= CW'(GAP_CYC - 1);
        end else d_cnt <= d_cnt - 1'b1;
        D_GAP: if (d_cnt == '0) d_st <= D_IDLE;
               else d_cnt <= d_cnt - 1'b1;
        default: d_st <= D_IDLE;
      endcase
    end
  end

  AST_STB_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    src_stb_out |-> src_bus_oe); // R2
  AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (src_bus_oe && $past(src_bus_oe)) |-> $stable(src_bus_data)); // R3
  AST_BUSY_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    src_bus_oe |-> !src_ready); // R5
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |=> !dst_valid); // R4
  AST_DST_STB_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    dst_stb_out |-> mode); // R9
  AST_SRC_STB_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    src_stb_out |-> !mode); // R9
  AST_REQ_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dst_stb_out |-> dst_busy); // R6
endmodule

// File: tb/strobe_xfer_tb.sv
module strobe_xfer_tb;
  localparam int DW = 8, S = 2, P = 2, H = 2;
  localparam int L = S + 3;

  logic clk = 1'b0, rst_n = 1'b0, mode = 1'b0;
  logic src_valid = 1'b0, dst_req = 1'b0;
  logic [DW-1:0] src_data = '0;
  logic src_ready, src_bus_oe, src_stb_out, dst_busy, dst_stb_out, dst_valid;
  logic [DW-1:0] src_bus_data, dst_data, bus;
  logic src_stb_in, dst_stb_in;

  assign bus        = src_bus_oe ? src_bus_data : '0;
  assign src_stb_in = dst_stb_out;
  assign dst_stb_in = src_stb_out;

  strobe_xfer #(.DW(DW), .SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .src_bus_data(src_bus_data), .src_bus_oe(src_bus_oe),
    .src_stb_out(src_stb_out), .src_stb_in(src_stb_in),
    .dst_req(dst_req), .dst_busy(dst_busy), .dst_stb_out(dst_stb_out),
    .dst_stb_in(dst_stb_in), .dst_bus_data(bus),
    .dst_valid(dst_valid), .dst_data(dst_data));

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  integer m_st = -1, m_dt = -1;
  logic m_armed = 0, m_drv = 0, m_dv = 0;
  logic [DW-1:0] m_word = '0, m_ddata = '0;
  string m_dtag = "R4";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = -1; m_dt = -1; m_armed = 0; m_drv = 0; m_dv = 0;
    end else begin
      m_dv = 0;
      if (!mode) begin
        if (m_st == S + 2) begin m_dv = 1; m_ddata = m_word; m_dtag = "R4"; end
        if (m_st < 0) begin
          if (src_valid) begin m_st = 0; m_word = src_data; end
        end else if (m_st == S + P + H - 1) m_st = -1;
        else m_st++;
      end else begin
        automatic integer pre = m_dt;
        automatic logic idle_pre = !m_armed && !m_drv;
        if (pre == L - 1) begin
          m_dv = 1;
          m_ddata = m_drv ? m_word : '0;
          m_dtag = m_drv ? "R6" : "R8";
        end
        if (m_drv && pre == L + H + 2) m_drv = 0;
        if (idle_pre) begin
          if (src_valid) begin m_armed = 1; m_word = src_data; end
        end else if (m_armed && pre == 2) begin
          m_drv = 1; m_armed = 0;
        end
        if (pre < 0) begin
          if (dst_req) m_dt = 0;
        end else if (pre == L + H + 2) m_dt = -1;
        else m_dt++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(mode ? "R7" : "R3", int'(src_bus_oe), int'(mode ? m_drv : (m_st >= 0)));
      if (src_bus_oe) chk("R2", int'(src_bus_data), int'(m_word));
      chk(mode ? "R9" : "R2", int'(src_stb_out), int'(!mode && m_st >= S && m_st < S + P));
      chk(mode ? "R6" : "R9", int'(dst_stb_out), int'(mode && m_dt >= 0 && m_dt < L));
      chk("R5", int'(src_ready), int'(mode ? (!m_armed && !m_drv) : (m_st < 0)));
      chk(mode ? "R6" : "R9", int'(dst_busy), int'(mode && m_dt >= 0));
      chk(mode ? "R6" : "R4", int'(dst_valid), int'(m_dv));
      if (m_dv) chk(m_dtag, int'(dst_data), int'(m_ddata));
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic send(input logic [DW-1:0] w);
    while (!src_ready) @(negedge clk);
    src_valid = 1; src_data = w;
    @(negedge clk);
    src_valid = 0;
  endtask

  task automatic request();
    while (dst_busy) @(negedge clk);
    dst_req = 1;
    @(negedge clk);
    dst_req = 0;
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  initial begin
    #8000000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    done = 1;
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", int'(src_bus_oe), 0);
    chk("R1", int'(src_stb_out), 0);
    chk("R1", int'(dst_stb_out), 0);
    chk("R1", int'(dst_busy), 0);
    chk("R1", int'(dst_valid), 0);
    chk("R1", int'(src_ready), 1);
    rst_n = 1;
    @(negedge clk);
    // R2 R3 R4: sender-started words
    send(8'hA5); send(8'h3C); send(8'hFF); send(8'h00);
    settle();
    // R5: continuous offer, data changes every cycle
    for (int i = 0; i < 40; i++) begin
      src_valid = 1; src_data = 8'(i * 7 + 1);
      @(negedge clk);
    end
    src_valid = 0;
    settle();
    // R9: request ignored when sender starts transfers
    dst_req = 1; repeat (6) @(negedge clk); dst_req = 0;
    settle();
    mode = 1;
    @(negedge clk);
    // R6 R7: armed word answered
    send(8'h5A); request(); settle();
    send(8'hC3); request(); settle();
    // R8: nothing armed
    request(); settle();
    // R8: arm on the same edge the rise is detected
    dst_req = 1; @(negedge clk); dst_req = 0;
    @(negedge clk); @(negedge clk);
    src_valid = 1; src_data = 8'h96; @(negedge clk); src_valid = 0;
    settle();
    request(); settle();
    // R6: request held high through busy, offers held too
    dst_req = 1; src_valid = 1; src_data = 8'h11;
    repeat (30) @(negedge clk);
    dst_req = 0; src_valid = 0;
    settle();
    done = 1;
    summary();
  end
endmodule